// File: doc/BRIEF.md
# Bus Start/Stop Condition Watcher

This block observes the data and clock lines of a two-wire serial bus (I2C) and reports bus framing conditions to software. A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. Both conditions raise the same interrupt request. Software reads a bus-busy flag to learn which one happened: the flag is set by an accepted START and cleared by an accepted STOP.

A data edge counts only if the clock line was high for more than a minimum number of timing ticks before the edge. The clock line must also stay high for more than a minimum number of ticks after the edge. Ticks come from the system clock, either undivided or divided by two, as a select input chooses. This filters out data transitions that come too close to clock activity. Both line inputs pass through a two-flop synchroniser before any edge is looked for. The interrupt request stays high until software acknowledges it.

Top module: `bus_cond_watch`

## Requirements
- R1: A falling data edge with the clock line high, meeting both timing windows, sets the interrupt request and sets the bus-busy flag.
- R2: A rising data edge with the clock line high, meeting both timing windows, sets the interrupt request and clears the bus-busy flag. This also happens when the flag is already clear.
- R3: Data edges while the clock line is low set no interrupt and leave the bus-busy flag unchanged.
- R4: An edge is accepted only if the number of ticks counted while the clock line was high before the edge is greater than SETUP_TICKS. With a tick on every clock, N cycles of clock line high at the pins before the data edge count as N ticks.
- R5: An edge is accepted only if the clock line stays high for at least HOLD_TICKS+1 ticks from the data edge on. With a tick on every clock, M cycles of clock line high at the pins after the data edge must satisfy M > HOLD_TICKS. A clock-line fall before that point drops the event.
- R6: With tick_slow_i = 0 a tick occurs on every clock cycle. With tick_slow_i = 1 a tick occurs on every second cycle, so both windows need twice as many clock cycles.
- R7: The interrupt request stays high until irq_ack_i is sampled high, and it goes low on the following clock edge. A new accepted event in the same cycle as an acknowledge keeps it high.
- R8: After reset the interrupt request and the bus-busy flag are both low.
- R9: A second data edge with the clock line high, arriving while an event is still in its hold window, replaces the pending event. Only the later edge can then be reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sda_i | input | 1 | Data line sample from the bus |
| scl_i | input | 1 | Clock line sample from the bus |
| tick_slow_i | input | 1 | 0: tick every cycle, 1: tick every second cycle |
| irq_ack_i | input | 1 | Clears the interrupt request |
| irq_o | output | 1 | Shared START/STOP interrupt request, sticky |
| busy_o | output | 1 | Bus busy: 1 after START, 0 after STOP |

## Verification
The bench builds the block with SETUP_TICKS = 3 and HOLD_TICKS = 6. Because the two values differ, swapping the two windows or using one threshold for both shows up as a wrong accept or reject. With a tick on every cycle, the accept and reject boundaries fall on exact clock counts, so the strict comparison and the single-cycle margins on each side can be tested directly. The divided tick is tested at counts that pass undivided and fail divided.

// File: rtl/bcw_pkg.sv
`timescale 1ns/1ps
package bcw_pkg;
  // Kind of bus condition held while the hold window is checked.
  typedef enum logic {
    EV_START = 1'b0,
    EV_STOP  = 1'b1
  } ev_kind_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bcw_sync.sv
`timescale 1ns/1ps
module bcw_sync #(
  parameter int unsigned   WIDTH   = 2,
  parameter int unsigned   STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [STAGES-1:0][WIDTH-1:0] stg_d;

  always_comb begin
    stg_d[0] = d_i;
    for (int k = 1; k < STAGES; k++) begin
      stg_d[k] = stg_q[k-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q <= stg_d;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bcw_tick.sv
`timescale 1ns/1ps
module bcw_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slow_i,
  output logic tick_o
);
  logic phase_q;
  logic phase_d;

  always_comb begin
    phase_d = ~phase_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
    end
  end

  // Undivided: every cycle. Divided: on one phase of the toggle.
  assign tick_o = slow_i ? phase_q : 1'b1;
endmodule

// File: rtl/bcw_cond.sv
`timescale 1ns/1ps
module bcw_cond
  import bcw_pkg::*;
#(
  parameter int unsigned SETUP_TICKS = 4,
  parameter int unsigned HOLD_TICKS  = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sda_s_i,
  input  logic     scl_s_i,
  input  logic     tick_i,
  output logic     fire_o,
  output ev_kind_e kind_o
);
  localparam int unsigned CMAX = max2(SETUP_TICKS, HOLD_TICKS) + 1;
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(CMAX);
  localparam logic [CW-1:0] SETUP_L = CW'(SETUP_TICKS);
  localparam logic [CW-1:0] HOLD_L  = CW'(HOLD_TICKS);
  localparam logic [CW-1:0] ONE_L   = CW'(1);

  logic          sda_p_q, scl_p_q;
  logic [CW-1:0] scl_cnt_q, scl_cnt_d;
  logic [CW-1:0] hold_q, hold_d;
  logic          pend_q, pend_d;
  ev_kind_e      kind_q, kind_d;
  logic          sda_fall, sda_rise, scl_held, fire;

  always_comb begin
    sda_fall = sda_p_q & ~sda_s_i;
    sda_rise = ~sda_p_q & sda_s_i;
    scl_held = scl_s_i & scl_p_q;

    // Saturating count of ticks spent with the clock line high.
    scl_cnt_d = scl_cnt_q;
    if (!scl_s_i) begin
      scl_cnt_d = '0;
    end else if (tick_i && (scl_cnt_q != CNT_MAX)) begin
      scl_cnt_d = scl_cnt_q + ONE_L;
    end

    pend_d = pend_q;
    kind_d = kind_q;
    hold_d = hold_q;
    fire   = 1'b0;
    if (scl_held && (sda_fall || sda_rise)) begin
      // A qualifying edge always replaces whatever is pending.
      pend_d = (scl_cnt_q > SETUP_L);
      kind_d = sda_rise ? EV_STOP : EV_START;
      hold_d = tick_i ? ONE_L : '0;
    end else if (pend_q) begin
      if (!scl_s_i) begin
        pend_d = 1'b0;
      end else if (tick_i) begin
        if (hold_q == HOLD_L) begin
          fire   = 1'b1;
          pend_d = 1'b0;
        end else begin
          hold_d = hold_q + ONE_L;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_p_q   <= 1'b1;
      scl_p_q   <= 1'b1;
      scl_cnt_q <= '0;
      hold_q    <= '0;
      pend_q    <= 1'b0;
      kind_q    <= EV_START;
    end else begin
      sda_p_q   <= sda_s_i;
      scl_p_q   <= scl_s_i;
      scl_cnt_q <= scl_cnt_d;
      hold_q    <= hold_d;
      pend_q    <= pend_d;
      kind_q    <= kind_d;
    end
  end

  assign fire_o = fire;
  assign kind_o = kind_q;
endmodule

// File: rtl/bus_cond_watch.sv
`timescale 1ns/1ps
module bus_cond_watch
  import bcw_pkg::*;
#(
  parameter int unsigned SETUP_TICKS = 4,
  parameter int unsigned HOLD_TICKS  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  input  logic tick_slow_i,
  input  logic irq_ack_i,
  output logic irq_o,
  output logic busy_o
);
  logic [1:0] rst_pipe_q;
  logic       rst_n;
  logic [1:0] line_s;
  logic       sda_s, scl_s, tick, fire;
  ev_kind_e   kind;
  logic       irq_q, irq_d, busy_q, busy_d;

  // Reset asserts at once and releases on the clock.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n = rst_pipe_q[1];

  bcw_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b11)
  ) line_sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   ({sda_i, scl_i}),
    .q_o   (line_s)
  );
  assign sda_s = line_s[1];
  assign scl_s = line_s[0];

  bcw_tick tick_i (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .slow_i(tick_slow_i),
    .tick_o(tick)
  );

  bcw_cond #(
    .SETUP_TICKS(SETUP_TICKS),
    .HOLD_TICKS (HOLD_TICKS)
  ) cond_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .sda_s_i(sda_s),
    .scl_s_i(scl_s),
    .tick_i (tick),
    .fire_o (fire),
    .kind_o (kind)
  );

  always_comb begin
    irq_d  = irq_q;
    busy_d = busy_q;
    if (fire) begin
      irq_d  = 1'b1;
      busy_d = (kind == EV_START);
    end else if (irq_ack_i) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      irq_q  <= irq_d;
      busy_q <= busy_d;
    end
  end

  assign irq_o  = irq_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/bcw_chk.sv
`timescale 1ns/1ps
module bcw_chk (
  input logic clk_i,
  input logic rst_n,
  input logic irq_o,
  input logic busy_o,
  input logic irq_ack_i,
  input logic scl_s,
  input logic tick,
  input logic tick_slow_i
);
  // R1
  busy_moves_with_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(busy_o) |-> irq_o);

  // R7
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    irq_o && !irq_ack_i |=> irq_o);

  // R7
  irq_drop_needs_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $fell(irq_o) |-> $past(irq_ack_i));

  // R3
  irq_rise_scl_high_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq_o) |-> $past(scl_s));

  // R6
  slow_tick_spaced_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_slow_i && tick |=> !(tick_slow_i && tick));
endmodule

bind bus_cond_watch bcw_chk chk_i (
  .clk_i      (clk_i),
  .rst_n      (rst_n),
  .irq_o      (irq_o),
  .busy_o     (busy_o),
  .irq_ack_i  (irq_ack_i),
  .scl_s      (scl_s),
  .tick       (tick),
  .tick_slow_i(tick_slow_i)
);

// File: tb/bus_cond_watch_tb.sv
`timescale 1ns/1ps
module bus_cond_watch_tb_top;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sda = 1'b1;
  logic scl = 1'b1;
  logic slow = 1'b0;
  logic ack = 1'b0;
  logic irq, busy;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  bus_cond_watch #(
    .SETUP_TICKS(3),
    .HOLD_TICKS (6)
  ) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .sda_i      (sda),
    .scl_i      (scl),
    .tick_slow_i(slow),
    .irq_ack_i  (ack),
    .irq_o      (irq),
    .busy_o     (busy)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  // Clock low, preset data, raise clock for n_set cycles, flip data,
  // keep clock high m_hold cycles, drop clock and settle.
  task automatic run_cond(input bit stop, input int n_set, input int m_hold);
    scl = 1'b0;
    sda = stop ? 1'b0 : 1'b1;
    cyc(4);
    scl = 1'b1;
    cyc(n_set);
    sda = ~sda;
    cyc(m_hold);
    scl = 1'b0;
    cyc(12);
  endtask

  task automatic do_ack();
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
    cyc(1);
  endtask

  task automatic t_reset();
    chk("R8 irq after reset", irq, 1'b0);
    chk("R8 busy after reset", busy, 1'b0);
  endtask

  task automatic t_start_stop();
    slow = 1'b0;
    run_cond(1'b0, 4, 7);
    chk("R1 start irq", irq, 1'b1);
    chk("R1 start busy", busy, 1'b1);
    cyc(20);
    chk("R7 irq held without ack", irq, 1'b1);
    do_ack();
    chk("R7 irq cleared by ack", irq, 1'b0);
    run_cond(1'b1, 4, 7);
    chk("R2 stop irq", irq, 1'b1);
    chk("R2 stop busy", busy, 1'b0);
    do_ack();
    run_cond(1'b1, 5, 9);
    chk("R2 stop while free irq", irq, 1'b1);
    chk("R2 stop while free busy", busy, 1'b0);
    do_ack();
  endtask

  task automatic t_scl_low();
    run_cond(1'b0, 5, 9);
    do_ack();
    chk("R3 setup busy", busy, 1'b1);
    scl = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sda = ~sda;
      cyc(3);
    end
    cyc(10);
    chk("R3 irq with clock low", irq, 1'b0);
    chk("R3 busy with clock low", busy, 1'b1);
    run_cond(1'b1, 5, 9);
    do_ack();
  endtask

  task automatic t_windows();
    run_cond(1'b0, 3, 7);
    chk("R4 setup equal to limit irq", irq, 1'b0);
    chk("R4 setup equal to limit busy", busy, 1'b0);
    run_cond(1'b0, 4, 6);
    chk("R5 hold equal to limit irq", irq, 1'b0);
    chk("R5 hold equal to limit busy", busy, 1'b0);
  endtask

  task automatic t_slow();
    slow = 1'b1;
    cyc(2);
    run_cond(1'b0, 6, 20);
    chk("R6 slow setup short", irq, 1'b0);
    run_cond(1'b0, 8, 20);
    chk("R6 slow setup ok irq", irq, 1'b1);
    chk("R6 slow setup ok busy", busy, 1'b1);
    do_ack();
    run_cond(1'b1, 10, 12);
    chk("R6 slow hold short irq", irq, 1'b0);
    chk("R6 slow hold short busy", busy, 1'b1);
    run_cond(1'b1, 10, 14);
    chk("R6 slow hold ok irq", irq, 1'b1);
    chk("R6 slow hold ok busy", busy, 1'b0);
    do_ack();
    slow = 1'b0;
    cyc(2);
  endtask

  task automatic t_two_events();
    run_cond(1'b0, 6, 9);
    run_cond(1'b1, 6, 9);
    chk("R7 irq after two events", irq, 1'b1);
    chk("R2 busy after start then stop", busy, 1'b0);
    do_ack();
    chk("R7 irq cleared after two events", irq, 1'b0);
  endtask

  task automatic t_replace();
    scl = 1'b0;
    sda = 1'b1;
    cyc(4);
    scl = 1'b1;
    cyc(8);
    sda = 1'b0;
    cyc(2);
    sda = 1'b1;
    cyc(10);
    scl = 1'b0;
    cyc(12);
    chk("R9 replaced event irq", irq, 1'b1);
    chk("R9 replaced event busy", busy, 1'b0);
    do_ack();
  endtask

  initial begin
    cyc(3);
    rst_ni = 1'b1;
    cyc(8);
    t_reset();
    t_start_stop();
    t_scl_low();
    t_windows();
    t_slow();
    t_two_events();
    t_replace();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule